// File: doc/BRIEF.md
# Hash Accelerator Control Register Front-End

This block is the software-facing control layer of a hash accelerator. A processor writes a source address, a digest address and a byte count into three registers. It then writes a command word that picks the hash algorithm and the byte-order options. The command write launches one job towards an attached hash datapath through a start/done handshake. The datapath itself is outside this block.

While a job runs, the block reports busy and holds the job parameters steady. When the datapath signals completion, busy drops and a sticky completion flag is raised. The completion flag drives the interrupt output. Software clears the flag by writing a one to its bit. The address and length registers implement only part of the 32-bit word, and the bits that are not implemented always read as zero.

Register byte offsets: source address 0x00, digest address 0x04, length 0x08, command 0x0C, status 0x10. Reads from any other offset return zero.

Top module: `hashreg_frontend`

## Requirements
- R1: The source address register stores only bits 30:0. Writing 0xFFFFFFFF reads back 0x7FFFFFFF.
- R2: The digest address register stores only bits 30:3, so it is always 8-byte aligned. Writing 0xFFFFFFFF reads back 0x7FFFFFF8.
- R3: The length register stores only bits 27:0. Writing 0xFFFFFFFF reads back 0x0FFFFFFF.
- R4: After reset, all five registers read zero, `irq` is low and `job_start` is low.
- R5: Command bits {10,6,5,4} select `job_algo` as follows: 0000 gives MD5 (code 0), 0010 gives SHA1 (code 1), 0100 gives SHA224 (code 2), 0101 gives SHA256 (code 3), 1110 gives SHA384 (code 4), 0110 gives SHA512 (code 5), and any other pattern gives code 7. Command bit 3 drives `job_sha_be` and bit 2 drives `job_md5_le`.
- R6: A command write while idle pulses `job_start` high for exactly the one cycle after the write. In that same cycle, `job_src`, `job_dst` and `job_len` carry the register values held at the write, and status bit 0 (busy) reads 1.
- R7: A `job_done` pulse while busy makes the status register read exactly 0x00000200 from the next cycle on.
- R8: Writing a word with bit 9 set to the status register clears the completion flag, and status then reads zero.
- R9: Writing zero to status bit 9 leaves the flag unchanged, and status bit 0 cannot be changed by a write.
- R10: `irq` is high exactly while the completion flag (status bit 9) is set.
- R11: A command write while busy starts nothing: `job_start` stays low and the job outputs hold. The address registers stay writable while busy, and their readback changes while the job outputs do not.
- R12: The command register reads back the last accepted command word masked to bits {10,6,5,4,3,2} (mask 0x47C).
- R13: A `job_done` pulse while idle has no effect on status or `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| job_start | output | 1 | One-cycle launch pulse to the datapath |
| job_algo | output | 3 | Selected algorithm code |
| job_sha_be | output | 1 | Big-endian SHA option |
| job_md5_le | output | 1 | Little-endian MD5 option |
| job_src | output | 32 | Source address latched at launch |
| job_dst | output | 32 | Digest address latched at launch |
| job_len | output | 32 | Byte count latched at launch |
| job_done | input | 1 | Completion pulse from the datapath |
| irq | output | 1 | Completion interrupt |

## Verification
The bench builds the block with its default parameters. These are a 32-bit data path, a 5-bit offset, the keep masks 0x7FFFFFFF, 0x7FFFFFF8, 0x0FFFFFFF and 0x47C, and command readback enabled. With these settings, every implemented and unimplemented address bit can be seen through all-ones writes. Every algorithm pattern can be launched and its latched command read back. The busy window is held open long enough to try both re-launch attempts and register rewrites against the held job outputs.

// File: rtl/hashreg_pkg.sv
package hashreg_pkg;
   typedef enum logic [2:0] {
      ALG_MD5    = 3'd0,
      ALG_SHA1   = 3'd1,
      ALG_SHA224 = 3'd2,
      ALG_SHA256 = 3'd3,
      ALG_SHA384 = 3'd4,
      ALG_SHA512 = 3'd5,
      ALG_OTHER  = 3'd7
   } hash_algo_e;

   localparam int CMD_MD5_LE_BIT = 2;
   localparam int CMD_SHA_BE_BIT = 3;
   localparam int CMD_SEL_B0     = 4;
   localparam int CMD_SEL_B1     = 5;
   localparam int CMD_SEL_B2     = 6;
   localparam int CMD_SEL_B3     = 10;

   localparam int STS_BUSY_BIT   = 0;
   localparam int STS_DONE_BIT   = 9;
endpackage

// File: rtl/hashreg_masked_reg.sv
module hashreg_masked_reg #(
   parameter int          W    = 32,
   parameter logic [W-1:0] KEEP = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         we,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (we) q <= wdata & KEEP;
   end

   // R1 R2 R3: unimplemented bits never hold a one
   a_r1_keep_mask: assert property (@(posedge clk) disable iff (!rst_n)
      (q & ~KEEP) == '0);
endmodule

// File: rtl/hashreg_cmd_decode.sv
module hashreg_cmd_decode
   import hashreg_pkg::*;
(
   input  logic [3:0] sel,
   input  logic       be_bit,
   input  logic       le_bit,
   output hash_algo_e algo,
   output logic       sha_be,
   output logic       md5_le
);
   always_comb begin
      unique case (sel)
         4'b0000: algo = ALG_MD5;
         4'b0010: algo = ALG_SHA1;
         4'b0100: algo = ALG_SHA224;
         4'b0101: algo = ALG_SHA256;
         4'b0110: algo = ALG_SHA512;
         4'b1110: algo = ALG_SHA384;
         default: algo = ALG_OTHER;
      endcase
      sha_be = be_bit;
      md5_le = le_bit;
   end
endmodule

// File: rtl/hashreg_job_ctrl.sv
module hashreg_job_ctrl #(
   parameter int           W        = 32,
   parameter logic [W-1:0] CMD_KEEP = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         cmd_we,
   input  logic [W-1:0] cmd_wdata,
   input  logic [W-1:0] src_q,
   input  logic [W-1:0] dst_q,
   input  logic [W-1:0] len_q,
   input  logic         sts_clr,
   input  logic         job_done,
   output logic         busy_q,
   output logic         done_q,
   output logic         job_start,
   output logic [W-1:0] job_cmd,
   output logic [W-1:0] job_src,
   output logic [W-1:0] job_dst,
   output logic [W-1:0] job_len
);
   logic launch, finish;

   assign launch = cmd_we && !busy_q;
   assign finish = busy_q && job_done;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q    <= 1'b0;
         done_q    <= 1'b0;
         job_start <= 1'b0;
         job_cmd   <= '0;
         job_src   <= '0;
         job_dst   <= '0;
         job_len   <= '0;
      end else begin
         job_start <= launch;
         if (launch) begin
            busy_q  <= 1'b1;
            job_cmd <= cmd_wdata & CMD_KEEP;
            job_src <= src_q;
            job_dst <= dst_q;
            job_len <= len_q;
         end else if (finish) begin
            busy_q  <= 1'b0;
         end
         if (finish)       done_q <= 1'b1;
         else if (sts_clr) done_q <= 1'b0;
      end
   end

   a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      job_start |=> !job_start);
   a_r7_finish: assert property (@(posedge clk) disable iff (!rst_n)
      finish |=> (!busy_q && done_q));
   a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (sts_clr && !finish) |=> !done_q);
   a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (!sts_clr && done_q) |=> done_q);
   a_r11_hold_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && cmd_we) |=> (!job_start && $stable(job_cmd) && $stable(job_src)
                              && $stable(job_dst) && $stable(job_len)));
   a_r13_idle_done: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_q && job_done && !done_q) |=> !done_q);
endmodule

// File: rtl/hashreg_frontend.sv
module hashreg_frontend
   import hashreg_pkg::*;
#(
   parameter int            DATA_W       = 32,
   parameter int            ADDR_W       = 5,
   parameter logic [31:0]   SRC_KEEP     = 32'h7FFF_FFFF,
   parameter logic [31:0]   DST_KEEP     = 32'h7FFF_FFF8,
   parameter logic [31:0]   LEN_KEEP     = 32'h0FFF_FFFF,
   parameter logic [31:0]   CMD_KEEP     = 32'h0000_047C,
   parameter bit            CMD_READBACK = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              job_start,
   output logic [2:0]        job_algo,
   output logic              job_sha_be,
   output logic              job_md5_le,
   output logic [DATA_W-1:0] job_src,
   output logic [DATA_W-1:0] job_dst,
   output logic [DATA_W-1:0] job_len,
   input  logic              job_done,
   output logic              irq
);
   localparam int NREG = 3;
   localparam logic [ADDR_W-1:0] OFF_SRC = ADDR_W'(0);
   localparam logic [ADDR_W-1:0] OFF_DST = ADDR_W'(4);
   localparam logic [ADDR_W-1:0] OFF_LEN = ADDR_W'(8);
   localparam logic [ADDR_W-1:0] OFF_CMD = ADDR_W'(12);
   localparam logic [ADDR_W-1:0] OFF_STS = ADDR_W'(16);
   localparam logic [NREG*DATA_W-1:0] KEEPS =
      {DATA_W'(LEN_KEEP), DATA_W'(DST_KEEP), DATA_W'(SRC_KEEP)};

   if (DATA_W != 32) begin : g_bad_width
      $error("hashreg_frontend: DATA_W must be 32");
   end
   if (ADDR_W < 5) begin : g_bad_addr
      $error("hashreg_frontend: ADDR_W must reach offset 0x10");
   end

   logic [ADDR_W-1:0]      reg_offs [NREG];
   logic [DATA_W-1:0]      reg_q    [NREG];
   logic [DATA_W-1:0]      job_cmd;
   logic [DATA_W-1:0]      cmd_rd;
   logic [DATA_W-1:0]      sts_rd;
   logic                   busy_q, done_q;
   hash_algo_e             algo;

   assign reg_offs[0] = OFF_SRC;
   assign reg_offs[1] = OFF_DST;
   assign reg_offs[2] = OFF_LEN;

   for (genvar i = 0; i < NREG; i++) begin : g_areg
      hashreg_masked_reg #(
         .W    (DATA_W),
         .KEEP (KEEPS[i*DATA_W +: DATA_W])
      ) u_reg (
         .clk   (clk),
         .rst_n (rst_n),
         .we    (reg_we && (reg_addr == reg_offs[i])),
         .wdata (reg_wdata),
         .q     (reg_q[i])
      );
   end

   hashreg_job_ctrl #(
      .W        (DATA_W),
      .CMD_KEEP (DATA_W'(CMD_KEEP))
   ) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_we    (reg_we && (reg_addr == OFF_CMD)),
      .cmd_wdata (reg_wdata),
      .src_q     (reg_q[0]),
      .dst_q     (reg_q[1]),
      .len_q     (reg_q[2]),
      .sts_clr   (reg_we && (reg_addr == OFF_STS) && reg_wdata[STS_DONE_BIT]),
      .job_done  (job_done),
      .busy_q    (busy_q),
      .done_q    (done_q),
      .job_start (job_start),
      .job_cmd   (job_cmd),
      .job_src   (job_src),
      .job_dst   (job_dst),
      .job_len   (job_len)
   );

   hashreg_cmd_decode u_dec (
      .sel    ({job_cmd[CMD_SEL_B3], job_cmd[CMD_SEL_B2],
                job_cmd[CMD_SEL_B1], job_cmd[CMD_SEL_B0]}),
      .be_bit (job_cmd[CMD_SHA_BE_BIT]),
      .le_bit (job_cmd[CMD_MD5_LE_BIT]),
      .algo   (algo),
      .sha_be (job_sha_be),
      .md5_le (job_md5_le)
   );
   assign job_algo = algo;

   if (CMD_READBACK) begin : g_cmd_rb
      assign cmd_rd = job_cmd;
   end else begin : g_cmd_zero
      assign cmd_rd = '0;
   end

   always_comb begin
      sts_rd               = '0;
      sts_rd[STS_BUSY_BIT] = busy_q;
      sts_rd[STS_DONE_BIT] = done_q;
   end

   always_comb begin
      unique case (reg_addr)
         OFF_SRC: reg_rdata = reg_q[0];
         OFF_DST: reg_rdata = reg_q[1];
         OFF_LEN: reg_rdata = reg_q[2];
         OFF_CMD: reg_rdata = cmd_rd;
         OFF_STS: reg_rdata = sts_rd;
         default: reg_rdata = '0;
      endcase
   end

   assign irq = |sts_rd[DATA_W-1:1];

   a_r10_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past(job_done));
   a_r6_busy_follows_start: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(job_start) |-> sts_rd[STS_BUSY_BIT]);
endmodule

// File: tb/hashreg_frontend_tb_top.sv
module hashreg_frontend_tb_top;
   localparam logic [4:0] A_SRC = 5'd0, A_DST = 5'd4, A_LEN = 5'd8,
                          A_CMD = 5'd12, A_STS = 5'd16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [4:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        job_start;
   logic [2:0]  job_algo;
   logic        job_sha_be, job_md5_le;
   logic [31:0] job_src, job_dst, job_len;
   logic        job_done = 1'b0;
   logic        irq;

   int checks = 0;
   int fails  = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   hashreg_frontend dut_i (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .job_start(job_start),
      .job_algo(job_algo), .job_sha_be(job_sha_be), .job_md5_le(job_md5_le),
      .job_src(job_src), .job_dst(job_dst), .job_len(job_len),
      .job_done(job_done), .irq(irq)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [4:0] a, output logic [31:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic pulse_done();
      @(negedge clk);
      job_done = 1'b1;
      @(negedge clk);
      job_done = 1'b0;
   endtask

   task automatic t_reset();
      logic [31:0] v;
      rd(A_SRC, v); check("R4 src", v, 0);
      rd(A_DST, v); check("R4 dst", v, 0);
      rd(A_LEN, v); check("R4 len", v, 0);
      rd(A_CMD, v); check("R4 R12 cmd", v, 0);
      rd(A_STS, v); check("R4 sts", v, 0);
      check("R4 irq", {31'd0, irq}, 0);
      check("R4 job_start", {31'd0, job_start}, 0);
   endtask

   task automatic t_masks();
      logic [31:0] v;
      wr(A_SRC, 32'hFFFF_FFFF); rd(A_SRC, v); check("R1 src mask", v, 32'h7FFF_FFFF);
      wr(A_DST, 32'hFFFF_FFFF); rd(A_DST, v); check("R2 dst mask", v, 32'h7FFF_FFF8);
      wr(A_LEN, 32'hFFFF_FFFF); rd(A_LEN, v); check("R3 len mask", v, 32'h0FFF_FFFF);
      wr(A_SRC, 0); wr(A_DST, 0); wr(A_LEN, 0);
      rd(A_SRC, v); check("R1 src zero", v, 0);
      rd(A_DST, v); check("R2 dst zero", v, 0);
      rd(A_LEN, v); check("R3 len zero", v, 0);
   endtask

   task automatic t_idle_status();
      logic [31:0] v;
      wr(A_STS, 32'h0000_0001); rd(A_STS, v); check("R9 busy bit read-only", v, 0);
      pulse_done(); rd(A_STS, v); check("R13 idle done sts", v, 0);
      check("R13 idle done irq", {31'd0, irq}, 0);
   endtask

   task automatic t_job(input logic [31:0] cmd, input logic [2:0] exp_algo,
                        input logic exp_be, input logic exp_le);
      logic [31:0] v;
      wr(A_SRC, 32'h9234_5671);
      wr(A_DST, 32'hA000_0017);
      wr(A_LEN, 32'hF000_0003);
      wr(A_CMD, cmd);
      check("R6 start pulse", {31'd0, job_start}, 1);
      check("R6 job_src", job_src, 32'h1234_5671);
      check("R6 job_dst", job_dst, 32'h2000_0010);
      check("R6 job_len", job_len, 32'h0000_0003);
      check("R5 algo", {29'd0, job_algo}, {29'd0, exp_algo});
      check("R5 sha_be", {31'd0, job_sha_be}, {31'd0, exp_be});
      check("R5 md5_le", {31'd0, job_md5_le}, {31'd0, exp_le});
      rd(A_STS, v); check("R6 busy", v, 32'h0000_0001);
      @(negedge clk);
      check("R6 pulse ends", {31'd0, job_start}, 0);
      wr(A_CMD, 32'h0000_0028);
      check("R11 no relaunch", {31'd0, job_start}, 0);
      check("R11 algo held", {29'd0, job_algo}, {29'd0, exp_algo});
      wr(A_SRC, 32'h0000_0055);
      rd(A_SRC, v); check("R11 src writable", v, 32'h0000_0055);
      check("R11 job_src held", job_src, 32'h1234_5671);
      rd(A_CMD, v); check("R12 cmd readback", v, cmd & 32'h0000_047C);
      check("R10 irq low while busy", {31'd0, irq}, 0);
      pulse_done();
      rd(A_STS, v); check("R7 done status", v, 32'h0000_0200);
      check("R10 irq high", {31'd0, irq}, 1);
      wr(A_STS, 32'h0000_0000); rd(A_STS, v); check("R9 zero write", v, 32'h0000_0200);
      wr(A_STS, 32'h0000_0001); rd(A_STS, v); check("R9 busy write", v, 32'h0000_0200);
      wr(A_STS, 32'h0000_0200); rd(A_STS, v); check("R8 w1c", v, 0);
      check("R10 irq low", {31'd0, irq}, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_masks();
      t_idle_status();
      t_job(32'h8000_0004, 3'd0, 1'b0, 1'b1);
      t_job(32'h0000_0028, 3'd1, 1'b1, 1'b0);
      t_job(32'h0000_0048, 3'd2, 1'b1, 1'b0);
      t_job(32'h0000_0058, 3'd3, 1'b1, 1'b0);
      t_job(32'h0000_0468, 3'd4, 1'b1, 1'b0);
      t_job(32'h0000_0068, 3'd5, 1'b1, 1'b0);
      t_job(32'h0000_0418, 3'd7, 1'b1, 1'b0);
      t_idle_status();
      if (!finished) begin
         finished = 1'b1;
         $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule